// File: doc/BRIEF.md
# Header-Tagged Packet FIFO

This block is the per-port buffer of a one-in, three-out packet router. It holds sixteen 9-bit words. Each word is a data byte plus a flag bit that is set only on the first byte of a packet. The router's write side pushes words into it. An external receiver pulls bytes out by raising a read enable whenever the FIFO reports that it is not empty.

While bytes leave the FIFO, the block follows the packet boundaries. Reading a flagged word opens a packet. Its length field sets how many more bytes belong to that packet: the payload plus one parity byte. The byte output is driven only while a packet is open. After the parity byte has been shown for one cycle, the bus goes to high impedance. A byte read with no packet open is never driven onto the bus. This happens when a timeout soft reset has discarded the header that went with it. The soft reset is active high. It flushes the whole store at once and releases the bus.

Top module: `hdr_pkt_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `full`=0, `empty`=1 and `rd_data`=8'h00 driven.
- R2: A word is stored at a rising edge when `wr_en` is 1, `full` is 0 and `soft_rst` is 0. A write while `full` is 1 is dropped, even if a read happens in the same cycle.
- R3: A read happens at a rising edge when `rd_en` is 1, `empty` is 0 and `soft_rst` is 0. A read while `empty` is 1 changes neither `rd_data` nor the flags.
- R4: Words leave in the order they were written. The byte part `wr_data[7:0]` of the word taken by a read appears on `rd_data` in the cycle after that edge, if the bus is driven.
- R5: `full` is 1 exactly when 16 words are stored, and `empty` is 1 exactly when none are.
- R6: A read and a write accepted in the same cycle both take effect, and the number of stored words stays the same.
- R7: `wr_data[8]`=1 marks a header. Its bits [7:2] give the payload length L, and bits [1:0] are an address that this block ignores. After a header is read, the next L+1 reads are driven on `rd_data`. In the cycle after the last of those bytes was shown, `rd_data` is high impedance.
- R8: `soft_rst`=1 at a rising edge empties the FIFO (`empty`=1, `full`=0) and turns `rd_data` to high impedance. It takes priority over reads and writes in that cycle.
- R9: A non-header word read while no packet is open leaves `rd_data` at high impedance.
- R10: Reading a header always drives `rd_data` again with the header byte, whatever state the bus was in before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| soft_rst | input | 1 | Timeout flush, active high, synchronous |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Bit 8 header flag, bits 7:0 byte |
| rd_en | input | 1 | Read request from the receiver |
| rd_data | output | 8 | Byte output, high impedance outside a packet |
| full | output | 1 | All 16 locations hold data |
| empty | output | 1 | No location holds data |

## Verification
The packet-tracking function is tested with packets of several lengths: zero payload, two payload bytes, and a fourteen-byte payload that fills the store exactly. These show whether the length field is decoded from the right bits and whether the release happens one byte early or late. Back-to-back simultaneous reads and writes separate a correct occupancy count from one that drifts. A flush in the middle of a packet, followed by orphan payload words, shows the difference between the bus being released by the flush and the bus being kept released for headerless bytes. A header read after those bytes checks that the bus is driven again.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_BITS = 2;
  localparam int LEN_W     = BYTE_W - ADDR_BITS;
  localparam int CNT_W     = LEN_W + 1;

  typedef struct packed {
    logic              hdr;
    logic [BYTE_W-1:0] data;
  } word_t;
endpackage

// File: rtl/hpf_ptrs.sv
module hpf_ptrs #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty
);
  logic [AW:0] wptr_q, rptr_q;

  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign empty = (wptr_q == rptr_q);

  assign wr_fire = wr_en && !full && !soft_rst;
  assign rd_fire = rd_en && !empty && !soft_rst;

  assign waddr = wptr_q[AW-1:0];
  assign raddr = rptr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_fire) wptr_q <= wptr_q + 1'b1;
      if (rd_fire) rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/hpf_mem.sv
module hpf_mem
  import hpf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int DEPTH = 1 << AW;

  word_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/hpf_track.sv
module hpf_track
  import hpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              rd_fire,
  input  word_t             rword,
  output logic [BYTE_W-1:0] out_byte,
  output logic              drv_en
);
  logic [CNT_W-1:0]  left_q;
  logic              last_q;
  logic              drv_q;
  logic [BYTE_W-1:0] byte_q;
  logic [LEN_W-1:0]  hdr_len;

  assign hdr_len = rword.data[BYTE_W-1:ADDR_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      last_q <= 1'b0;
      drv_q  <= 1'b1;
      byte_q <= '0;
    end else if (soft_rst) begin
      left_q <= '0;
      last_q <= 1'b0;
      drv_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      last_q <= 1'b0;
      if (rd_fire) begin
        byte_q <= rword.data;
        if (rword.hdr) begin
          left_q <= {1'b0, hdr_len} + CNT_W'(1);
          drv_q  <= 1'b1;
        end else if (left_q != '0) begin
          left_q <= left_q - CNT_W'(1);
          last_q <= (left_q == CNT_W'(1));
        end else begin
          drv_q <= 1'b0;
        end
      end else if (last_q) begin
        drv_q <= 1'b0;
      end
    end
  end

  assign out_byte = byte_q;
  assign drv_en   = drv_q;
endmodule

// File: rtl/hdr_pkt_fifo.sv
module hdr_pkt_fifo
  import hpf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [BYTE_W:0]   wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr;
  word_t         rword;
  logic [BYTE_W-1:0] out_byte;
  logic          drv_en;

  hpf_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(wr_en), .rd_en(rd_en),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .waddr(waddr), .raddr(raddr),
    .full(full), .empty(empty)
  );

  hpf_mem #(.AW(AW)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(waddr), .wdata(word_t'(wr_data)),
    .raddr(raddr), .rdata(rword)
  );

  hpf_track u_track (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .rd_fire(rd_fire), .rword(rword),
    .out_byte(out_byte), .drv_en(drv_en)
  );

  assign rd_data = drv_en ? out_byte : {BYTE_W{1'bz}};
endmodule

// File: rtl/hpf_checker.sv
module hpf_checker (
  input logic       clk,
  input logic       rst,
  input logic       soft_rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       full,
  input logic       empty,
  input logic       drv_en
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (empty && !full && (rd_data === 8'h00)));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !soft_rst) |=> full);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> empty);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_rw_keeps_level_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !full && !empty && !soft_rst) |=> (!full && !empty));

  assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (empty && !full && !drv_en));
endmodule

bind hdr_pkt_fifo hpf_checker u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .full(full), .empty(empty), .drv_en(drv_en)
);

// File: tb/hdr_pkt_fifo_bench.sv
module hdr_pkt_fifo_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       full, empty;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // scoreboard and bus model
  logic [8:0] exp_q[$];
  bit         m_drv = 1;
  logic [7:0] m_val = 8'h00;
  int         m_left = 0;
  bit         m_last = 0;

  always #2 clk = ~clk;

  hdr_pkt_fifo u_hdr_pkt_fifo (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty)
  );

  task automatic check_state(input string tag);
    logic [7:0] exp_d;
    exp_d = m_drv ? m_val : 8'bzzzzzzzz;
    checks++;
    if (rd_data !== exp_d) begin
      errors++;
      $display("FAIL %s rd_data act=%h exp=%h t=%0t", tag, rd_data, exp_d, $time);
    end
    checks++;
    if (full !== (exp_q.size() == 16)) begin
      errors++;
      $display("FAIL %s full act=%b exp=%b", tag, full, exp_q.size() == 16);
    end
    checks++;
    if (empty !== (exp_q.size() == 0)) begin
      errors++;
      $display("FAIL %s empty act=%b exp=%b", tag, empty, exp_q.size() == 0);
    end
  endtask

  task automatic cyc(input logic we, input logic [8:0] wd, input logic re,
                     input logic sr, input string tag);
    bit f_m, e_m, rf, wf, hdr_rd, nl;
    logic [8:0] w;
    @(negedge clk);
    wr_en = we; wr_data = wd; rd_en = re; soft_rst = sr;
    @(posedge clk);
    f_m = (exp_q.size() == 16);
    e_m = (exp_q.size() == 0);
    if (sr) begin
      exp_q.delete();
      m_drv = 0; m_left = 0; m_last = 0; m_val = 8'h00;
    end else begin
      rf = re && !e_m;
      wf = we && !f_m;
      hdr_rd = 0; nl = 0;
      if (rf) begin
        w = exp_q.pop_front();
        m_val = w[7:0];
        if (w[8]) begin
          hdr_rd = 1; m_drv = 1; m_left = int'(w[7:2]) + 1;
        end else if (m_left > 0) begin
          m_left--; nl = (m_left == 0);
        end else begin
          m_drv = 0;
        end
      end
      if (m_last && !hdr_rd) m_drv = 0;
      m_last = nl;
      if (wf) exp_q.push_back(wd);
    end
    #1;
    check_state(tag);
  endtask

  function automatic logic [8:0] hdr(input int len, input int addr);
    return {1'b1, 6'(len), 2'(addr)};
  endfunction

  function automatic logic [8:0] pay(input int b);
    return {1'b0, 8'(b)};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0;
    check_state("R1");

    // R3: read on empty is ignored
    cyc(0, '0, 1, 0, "R3");
    cyc(0, '0, 1, 0, "R3");

    // R7/R4: header with 2 payload bytes plus parity
    cyc(1, hdr(2, 1), 0, 0, "R4");
    cyc(1, pay(8'h5a), 0, 0, "R4");
    cyc(1, pay(8'hc3), 0, 0, "R4");
    cyc(1, pay(8'h9e), 0, 0, "R4");
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0, "R7");
    cyc(0, '0, 0, 0, "R7");
    cyc(0, '0, 0, 0, "R7");

    // R2/R5: fill with a 14-byte payload packet, then an extra dropped write
    cyc(1, hdr(14, 2), 0, 0, "R5");
    for (int i = 0; i < 14; i++) cyc(1, pay(8'h10 + i), 0, 0, "R5");
    cyc(1, pay(8'hee), 0, 0, "R5");
    cyc(1, pay(8'h77), 0, 0, "R2");
    cyc(1, pay(8'h66), 1, 0, "R2");
    for (int i = 0; i < 16; i++) cyc(0, '0, 1, 0, "R2");
    cyc(0, '0, 1, 0, "R3");

    // R6: simultaneous read and write
    cyc(1, hdr(5, 0), 0, 0, "R6");
    cyc(1, pay(8'h21), 0, 0, "R6");
    for (int i = 0; i < 5; i++) cyc(1, pay(8'h30 + i), 1, 0, "R6");
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0, "R6");
    cyc(0, '0, 0, 0, "R7");

    // R8: flush in the middle of a packet, with read and write requested
    cyc(1, hdr(3, 1), 0, 0, "R8");
    cyc(1, pay(8'h44), 0, 0, "R8");
    cyc(0, '0, 1, 0, "R8");
    cyc(1, pay(8'h45), 1, 1, "R8");
    cyc(0, '0, 1, 0, "R8");

    // R9: orphan payload bytes stay off the bus
    cyc(1, pay(8'hab), 0, 0, "R9");
    cyc(1, pay(8'hcd), 0, 0, "R9");
    cyc(0, '0, 1, 0, "R9");
    cyc(0, '0, 1, 0, "R9");

    // R10: header re-drives the bus, zero-length packet
    cyc(1, hdr(0, 3), 0, 0, "R10");
    cyc(1, pay(8'h03), 0, 0, "R10");
    cyc(0, '0, 1, 0, "R10");
    cyc(0, '0, 1, 0, "R10");
    cyc(0, '0, 0, 0, "R7");

    // R1: reset again with data held
    cyc(1, hdr(1, 0), 0, 0, "R1");
    @(negedge clk);
    wr_en = 0; rd_en = 0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    m_drv = 1; m_val = 8'h00; m_left = 0; m_last = 0;
    check_state("R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule